// File: doc/BRIEF.md
# Two-Wire Bus Clock Waveform Generator

This block times the serial clock of a two-wire bus master. It derives the clock from the system clock. A small configuration register holds three fields: a divider for the low phase, a divider for the high phase and a power-of-two prescaler exponent. Each phase lasts the divider shifted left by the exponent, plus a fixed offset of system clocks. When the two dividers are equal, the bus clock equals the system clock divided by twice that phase length. Software works out the divider values for the wanted rate, for example 100 kHz or at most 400 kHz. The block only applies the values it is given.

While enabled, the generator alternates low and high phases. It drives a level that tells the bus engine to pull the clock line low. It also gives a one-cycle enable on the last cycle of each phase. During the high phase it counts only cycles in which the sensed clock line is actually high. A device that stretches the clock therefore lengthens the phase instead of shortening it. When the block is disabled or in reset, it stays idle with the clock released. A register write never cuts short the phase in progress: new values are picked up at the next phase boundary.

Top module: `scl_waveform_gen`

## Requirements
- R1: After reset, and on every cycle after a cycle in which `enable` is low, `scl_low`, `low_end` and `high_end` are 0. After reset `cfg_rdata` reads 0.
- R2: `cfg_rdata` returns the stored register. The fields are the low divider in bits 7:0, the high divider in bits 15:8 and the exponent in bits 18:16. A write with `cfg_we` is visible on the following cycle.
- R3: An exponent written above `MAX_EXP` is stored and used as `MAX_EXP`.
- R4: The first low phase starts on the cycle after `enable` is first seen high. A low phase holds `scl_low` high for exactly (low divider << exponent) + `OFFSET` cycles.
- R5: A high phase lasts exactly (high divider << exponent) + `OFFSET` cycles in which `scl_in` is high. It is followed at once by the next low phase.
- R6: During a high phase, cycles with `scl_in` low do not advance the count. A stretch of K cycles lengthens the high phase by exactly K cycles.
- R7: A register write during a phase leaves that phase's length unchanged. Every later phase uses the new values.
- R8: `low_end` is high for exactly one cycle per low phase, on its last cycle. `high_end` is high for exactly one cycle per high phase, on its last counted cycle.
- R9: Dropping `enable` stops any phase at once. Enabling again starts with a full low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Master enable; low keeps the generator idle |
| cfg_we | input | 1 | Register write strobe |
| cfg_wdata | input | 19 | Register write data (low div 7:0, high div 15:8, exponent 18:16) |
| cfg_rdata | output | 19 | Stored register value |
| scl_in | input | 1 | Sensed level of the clock line |
| scl_low | output | 1 | 1 = pull the clock line low (low phase) |
| low_end | output | 1 | Last cycle of a low phase |
| high_end | output | 1 | Last counted cycle of a high phase |

## Verification
The bench builds the block with `OFFSET` = 3 and `MAX_EXP` = 5 instead of the defaults. With a prescaler limit below the 3-bit field maximum, writing exponent 7 shows the clamp, and a clamped phase is still only a few dozen cycles long. The small offset allows the shortest phase, three cycles, with divider 0. Short phases also let the bench place a register write and a stretch inside a single phase and then compare every resulting phase length.

// File: rtl/scl_waveform_gen.sv
module scl_waveform_gen #(
  parameter int OFFSET  = 4,
  parameter int MAX_EXP = 7,
  parameter int DIV_W   = 8,
  parameter int EXP_W   = 3
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         enable,
  input  logic                         cfg_we,
  input  logic [2*DIV_W+EXP_W-1:0]     cfg_wdata,
  output logic [2*DIV_W+EXP_W-1:0]     cfg_rdata,
  input  logic                         scl_in,
  output logic                         scl_low,
  output logic                         low_end,
  output logic                         high_end
);

  localparam int CFG_W  = 2*DIV_W + EXP_W;
  localparam int MAXLEN = (((2**DIV_W) - 1) << MAX_EXP) + OFFSET;
  localparam int LEN_W  = $clog2(MAXLEN + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LOW, PH_HIGH} phase_t;

  phase_t              ph;
  logic [LEN_W-1:0]    cnt;
  logic [LEN_W-1:0]    plen;
  logic [CFG_W-1:0]    cfg;

  logic [EXP_W-1:0]    wexp;
  logic [EXP_W-1:0]    wexp_cl;
  logic [LEN_W-1:0]    len_low;
  logic [LEN_W-1:0]    len_high;

  function automatic logic [LEN_W-1:0] phase_len(input logic [DIV_W-1:0] d,
                                                 input logic [EXP_W-1:0] e);
    return (LEN_W'(d) << e) + LEN_W'(OFFSET);
  endfunction

  assign wexp     = cfg_wdata[CFG_W-1 -: EXP_W];
  assign wexp_cl  = (int'(wexp) > MAX_EXP) ? EXP_W'(MAX_EXP) : wexp;
  assign len_low  = phase_len(cfg[DIV_W-1:0], cfg[CFG_W-1 -: EXP_W]);
  assign len_high = phase_len(cfg[2*DIV_W-1:DIV_W], cfg[CFG_W-1 -: EXP_W]);

  assign cfg_rdata = cfg;
  assign scl_low   = (ph == PH_LOW);
  assign low_end   = (ph == PH_LOW) && (cnt == plen - LEN_W'(1));
  assign high_end  = (ph == PH_HIGH) && scl_in && (cnt == plen - LEN_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg  <= '0;
      ph   <= PH_IDLE;
      cnt  <= '0;
      plen <= '0;
    end else begin
      if (cfg_we)
        cfg <= {wexp_cl, cfg_wdata[2*DIV_W-1:0]};
      if (!enable) begin
        ph  <= PH_IDLE;
        cnt <= '0;
      end else begin
        case (ph)
          PH_IDLE: begin
            ph   <= PH_LOW;
            cnt  <= '0;
            plen <= len_low;
          end
          PH_LOW: begin
            if (low_end) begin
              ph   <= PH_HIGH;
              cnt  <= '0;
              plen <= len_high;
            end else begin
              cnt <= cnt + LEN_W'(1);
            end
          end
          PH_HIGH: begin
            if (high_end) begin
              ph   <= PH_LOW;
              cnt  <= '0;
              plen <= len_low;
            end else if (scl_in) begin
              cnt <= cnt + LEN_W'(1);
            end
          end
          default: ph <= PH_IDLE;
        endcase
      end
    end
  end

  a_r1_disabled_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!scl_low && !low_end && !high_end));

  a_r3_exp_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> (int'(cfg_rdata[CFG_W-1 -: EXP_W]) <= MAX_EXP));

  a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE) |-> (cnt < plen));

  a_r6_stretch_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && ph == PH_HIGH && !scl_in) |=> (ph == PH_HIGH && $stable(cnt)));

  a_r7_len_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ph != PH_IDLE && enable && !low_end && !high_end) |=> $stable(plen));

  a_r8_low_to_high: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && low_end) |=> (ph == PH_HIGH && cnt == '0));

  a_r8_fall_needs_end: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(scl_low) && $past(enable)) |-> $past(low_end));

  a_r8_rise_from_high: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(scl_low) && $past(ph) == PH_HIGH) |-> $past(high_end));

endmodule

// File: tb/scl_waveform_gen_tb_top.sv
module scl_waveform_gen_tb_top;
  localparam int OFF  = 3;
  localparam int MEXP = 5;
  localparam int CW   = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic cfg_we = 1'b0;
  logic [CW-1:0] cfg_wdata = '0;
  logic [CW-1:0] cfg_rdata;
  logic scl_low, low_end, high_end, scl_in;
  logic stretch = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign scl_in = !(scl_low || stretch);

  scl_waveform_gen #(.OFFSET(OFF), .MAX_EXP(MEXP)) dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_we(cfg_we),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .scl_in(scl_in),
    .scl_low(scl_low), .low_end(low_end), .high_end(high_end));

  typedef struct {
    bit    is_low;
    int    len;
    int    wall;
    string tag;
  } item_t;

  item_t q[$];

  task automatic check(input string tag, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  function automatic logic [CW-1:0] mk(input int lo, input int hi, input int e);
    return {3'(e), 8'(hi), 8'(lo)};
  endfunction

  function automatic int plen(input int d, input int e);
    int ec = (e > MEXP) ? MEXP : e;
    return (d << ec) + OFF;
  endfunction

  task automatic push(input bit is_low, input int len, input int wall, input string tag);
    item_t it;
    it.is_low = is_low; it.len = len; it.wall = wall; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic sample();
    @(posedge clk); #1;
  endtask

  task automatic write_cfg(input logic [CW-1:0] v);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic set_en(input bit v);
    @(negedge clk); enable = v;
  endtask

  task automatic drain();
    int t = 0;
    while (q.size() != 0 && t < 5000) begin sample(); t++; end
    if (q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL drain: got %0d pending expected 0", q.size());
      q.delete();
    end
  endtask

  // monitor: measures phases and compares against the queue
  bit prev_low = 0, seen = 0;
  int lo_cnt = 0, lo_ends = 0, hi_cnt = 0, hi_wall = 0, hi_ends = 0;

  task automatic record(input bit is_low, input int len, input int wall, input int ends);
    item_t it;
    if (q.size() == 0) return;
    it = q.pop_front();
    check({it.tag, " kind"}, int'(is_low), int'(it.is_low));
    check({it.tag, " len"}, len, it.len);
    if (it.wall >= 0) check("R6 stretched wall length", wall, it.wall);
    check(is_low ? "R8 low_end per phase" : "R8 high_end per phase", ends, 1);
  endtask

  initial begin
    forever begin
      sample();
      if (!rst_n || !enable) begin
        prev_low = 0; seen = 0;
        lo_cnt = 0; lo_ends = 0; hi_cnt = 0; hi_wall = 0; hi_ends = 0;
      end else begin
        if (scl_low) begin
          if (!prev_low && seen) begin
            record(1'b0, hi_cnt, hi_wall, hi_ends);
            hi_cnt = 0; hi_wall = 0; hi_ends = 0;
          end
          lo_cnt++;
          lo_ends += int'(low_end);
          seen = 1;
        end else begin
          if (prev_low) begin
            record(1'b1, lo_cnt, 0, lo_ends);
            lo_cnt = 0; lo_ends = 0;
          end
          if (seen) begin
            hi_wall++;
            if (scl_in) hi_cnt++;
            hi_ends += int'(high_end);
          end
        end
        prev_low = scl_low;
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    sample();
    // R1 reset state
    check("R1 scl_low after reset", int'(scl_low), 0);
    check("R1 low_end after reset", int'(low_end), 0);
    check("R1 high_end after reset", int'(high_end), 0);
    check("R1 cfg_rdata after reset", int'(cfg_rdata), 0);
    repeat (4) sample();
    check("R1 disabled stays released", int'(scl_low), 0);

    // R2 readback, R4/R5 lengths, exp 0
    write_cfg(mk(2, 5, 0));
    sample();
    check("R2 readback", int'(cfg_rdata), int'(mk(2, 5, 0)));
    push(1, plen(2, 0), -1, "R4 low exp0");
    push(0, plen(5, 0), -1, "R5 high exp0");
    push(1, plen(2, 0), -1, "R4 low exp0 repeat");
    push(0, plen(5, 0), -1, "R5 high exp0 repeat");
    set_en(1); drain(); set_en(0);
    sample();
    check("R1 released after disable", int'(scl_low), 0);

    // exponent 2
    write_cfg(mk(1, 3, 2));
    push(1, plen(1, 2), -1, "R4 low exp2");
    push(0, plen(3, 2), -1, "R5 high exp2");
    set_en(1); drain(); set_en(0);

    // R3 clamp
    write_cfg(mk(1, 0, 7));
    sample();
    check("R3 exponent clamped", int'(cfg_rdata[18:16]), MEXP);
    check("R2 dividers kept with clamp", int'(cfg_rdata[15:0]), 16'h0001);
    push(1, plen(1, 7), -1, "R3 low clamped");
    push(0, plen(0, 7), -1, "R3 high clamped");
    set_en(1); drain(); set_en(0);

    // R7 write mid-phase
    write_cfg(mk(4, 4, 0));
    push(1, plen(4, 0), -1, "R7 phase in progress kept");
    push(0, plen(2, 1), -1, "R7 next high uses new");
    push(1, plen(1, 1), -1, "R7 next low uses new");
    push(0, plen(2, 1), -1, "R7 high new again");
    set_en(1);
    write_cfg(mk(1, 2, 1));
    drain(); set_en(0);

    // R6 stretch
    write_cfg(mk(0, 3, 0));
    push(1, plen(0, 0), -1, "R4 minimum low");
    push(0, plen(3, 0), plen(3, 0) + 4, "R6 stretched high count");
    push(1, plen(0, 0), -1, "R6 low after stretch");
    set_en(1);
    sample();
    while (scl_low) sample();
    @(negedge clk); stretch = 1'b1;
    repeat (4) @(negedge clk);
    stretch = 1'b0;
    drain(); set_en(0);

    // R9 abort and restart
    write_cfg(mk(10, 1, 0));
    set_en(1);
    repeat (5) sample();
    check("R9 low before abort", int'(scl_low), 1);
    set_en(0);
    sample();
    check("R9 released at once", int'(scl_low), 0);
    check("R9 no low_end on abort", int'(low_end), 0);
    push(1, plen(10, 0), -1, "R9 full low after restart");
    push(0, plen(1, 0), -1, "R9 high after restart");
    set_en(1); drain(); set_en(0);

    repeat (3) sample();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule